// File: doc/BRIEF.md
# Integer Compare-and-Set Execution Stage

This block is the execute step for an integer compare-and-set instruction in a GPU-style shader core. Each issued instruction brings its 64-bit encoding, operand A already read from the register file, and operand B already fetched from a register, constant or immediate. The predicate bits and the incoming carry and zero flags come with it. The unit compares A with B as signed or unsigned integers. It merges that outcome with a selected predicate, which may be inverted, through a boolean operation. On a true outcome it writes either an all-ones mask or the single-precision encoding of 1.0, and on a false outcome it writes zero.

Results leave the stage one clock after issue. They come with the destination index, a write enable and, when requested, updated zero, sign, carry and overflow flags. An extended mode treats A and B as the upper words of a wider comparison. In that mode the incoming flags describe how the lower words compared. Encodings the unit cannot execute raise an illegal-instruction strobe and suppress every write.

Top module: `icas_unit`

## Requirements
- R1: The compare op in instruction bits [51:49] selects the test of A against B: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. Bit 48 set makes the comparison two's-complement signed; clear makes it unsigned.
- R2: With bit 43 set (extended), A and B are the upper words of a wider compare. carryIn low means the lower A word was below the lower B word (borrow). carryIn high with zeroIn high means the lower words were equal. carryIn high with zeroIn low means the lower A word was above. Equality therefore needs equal upper words and zeroIn high.
- R3: Bits [41:39] pick one of the predicates predIn[6:0]. Index 7 reads as true whatever predIn[7] holds. Bit 42 inverts the picked predicate before it is combined.
- R4: Bits [46:45] combine the comparison with the predicate: 0 AND, 1 OR, 2 XOR. Code 3 raises illegal one cycle after issue and suppresses the register and flag writes.
- R5: A true combined outcome gives result 0xFFFFFFFF when bit 44 is clear, or 0x3F800000 when bit 44 is set. A false outcome gives 0.
- R6: Outputs register one cycle after issueValid, and resValid marks that cycle. destIdx carries bits [7:0]. destWe is high for a legal issue unless the index is 255, the zero register.
- R7: With bit 47 set (flag write), flagWe rises and zeroOut becomes 1 exactly when the result is 0.
- R8: With flag write, signOut becomes 0 when bit 44 is set, and otherwise becomes the inverse of zeroOut.
- R9: With flag write, carryOut and ovfOut become 0.
- R10: Flag write together with extended mode raises illegal and suppresses both the flag and register writes.
- R11: Reset clears every output. The flag outputs keep their values in every cycle without a flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction presented this cycle |
| instr | input | 64 | Instruction encoding |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| predIn | input | 8 | Predicate bits; bit 7 ignored |
| carryIn | input | 1 | Incoming carry flag |
| zeroIn | input | 1 | Incoming zero flag |
| resValid | output | 1 | Outputs below belong to an issue |
| result | output | 32 | Value to write |
| destIdx | output | 8 | Destination register index |
| destWe | output | 1 | Register write enable |
| flagWe | output | 1 | Flags were updated |
| zeroOut | output | 1 | Zero flag |
| signOut | output | 1 | Sign flag |
| carryOut | output | 1 | Carry flag |
| ovfOut | output | 1 | Overflow flag |
| illegal | output | 1 | Unsupported encoding issued |

## Verification
The bench builds the unit with its default 32-bit data width. At that width the float-one result and the all-ones mask both fill the word, and operands such as 0x80000000 and 0x7FFFFFFF split signed from unsigned ordering at the extreme values. Random encodings at this width reach every compare op, boolean code, predicate index and mode-bit combination. Directed vectors pin down the extended-mode tie rules, the reserved boolean code and the zero register.

// File: rtl/icas_pkg.sv
package icas_pkg;
  localparam int IDX_W  = 8;
  localparam int PSEL_W = 3;

  localparam int DEST_LSB = 0;
  localparam int SRCA_LSB = 8;
  localparam int PSEL_LSB = 39;
  localparam int PINV_BIT = 42;
  localparam int EXT_BIT  = 43;
  localparam int FRES_BIT = 44;
  localparam int BOP_LSB  = 45;
  localparam int CCW_BIT  = 47;
  localparam int SGN_BIT  = 48;
  localparam int CMP_LSB  = 49;

  typedef enum logic [1:0] {BOP_AND = 2'd0, BOP_OR = 2'd1, BOP_XOR = 2'd2, BOP_RSV = 2'd3} bop_e;

  typedef struct packed {
    logic [2:0]        cmpOp;
    bop_e              boolOp;
    logic              isSigned;
    logic              extended;
    logic              floatRes;
    logic              predInv;
    logic [PSEL_W-1:0] predSel;
    logic              flagWr;
    logic              destWr;
    logic              bad;
    logic [IDX_W-1:0]  dest;
  } icas_strobe_t;
endpackage

// File: rtl/icas_ctrl.sv
module icas_ctrl
  import icas_pkg::*;
(
  input  logic         issueValid,
  input  logic [63:0]  instr,
  output icas_strobe_t strb
);
  localparam logic [IDX_W-1:0] ZERO_REG = {IDX_W{1'b1}};

  logic badBop;
  logic badCc;
  logic ccReq;

  always_comb begin
    strb.cmpOp    = instr[CMP_LSB +: 3];
    strb.boolOp   = bop_e'(instr[BOP_LSB +: 2]);
    strb.isSigned = instr[SGN_BIT];
    strb.extended = instr[EXT_BIT];
    strb.floatRes = instr[FRES_BIT];
    strb.predInv  = instr[PINV_BIT];
    strb.predSel  = instr[PSEL_LSB +: PSEL_W];
    strb.dest     = instr[DEST_LSB +: IDX_W];
    ccReq         = instr[CCW_BIT];
    badBop        = (strb.boolOp == BOP_RSV);
    badCc         = ccReq & strb.extended;
    strb.bad      = issueValid & (badBop | badCc);
    strb.flagWr   = issueValid & ccReq & ~strb.bad;
    strb.destWr   = issueValid & ~strb.bad & (strb.dest != ZERO_REG);
  end
endmodule

// File: rtl/icas_dpath.sv
module icas_dpath
  import icas_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRED_N = 8
) (
  input  icas_strobe_t      strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [PRED_N-1:0] predIn,
  input  logic              carryIn,
  input  logic              zeroIn,
  output logic              relLt,
  output logic              relEq,
  output logic              relGt,
  output logic [DATA_W-1:0] resVal,
  output logic              zeroNew,
  output logic              signNew
);
  localparam logic [DATA_W-1:0] MASK_ONE  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] FLOAT_ONE = DATA_W'(32'h3F80_0000);

  logic hiLt, hiEq, hiGt;
  logic cmpHit, predBit, outcome;

  always_comb begin
    hiEq = (opA == opB);
    if (strb.isSigned) hiLt = ($signed(opA) < $signed(opB));
    else               hiLt = (opA < opB);
    hiGt = ~hiLt & ~hiEq;
    if (strb.extended) begin
      relLt = hiLt | (hiEq & ~carryIn);
      relEq = hiEq & carryIn & zeroIn;
      relGt = hiGt | (hiEq & carryIn & ~zeroIn);
    end else begin
      relLt = hiLt;
      relEq = hiEq;
      relGt = hiGt;
    end
    cmpHit = |(strb.cmpOp & {relGt, relEq, relLt});
  end

  always_comb begin
    if (strb.predSel == PSEL_W'(PRED_N - 1)) predBit = 1'b1;
    else                                     predBit = predIn[strb.predSel];
    predBit = predBit ^ strb.predInv;
    unique case (strb.boolOp)
      BOP_AND: outcome = cmpHit & predBit;
      BOP_OR:  outcome = cmpHit | predBit;
      BOP_XOR: outcome = cmpHit ^ predBit;
      default: outcome = 1'b0;
    endcase
    if (!outcome)          resVal = '0;
    else if (strb.floatRes) resVal = FLOAT_ONE;
    else                   resVal = MASK_ONE;
    zeroNew = (resVal == '0);
    signNew = strb.floatRes ? 1'b0 : ~zeroNew;
  end
endmodule

// File: rtl/icas_unit.sv
module icas_unit
  import icas_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [63:0]       instr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [7:0]        predIn,
  input  logic              carryIn,
  input  logic              zeroIn,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  destIdx,
  output logic              destWe,
  output logic              flagWe,
  output logic              zeroOut,
  output logic              signOut,
  output logic              carryOut,
  output logic              ovfOut,
  output logic              illegal
);
  icas_strobe_t      strb;
  logic              relLt, relEq, relGt;
  logic [DATA_W-1:0] resVal;
  logic              zeroNew, signNew;

  icas_ctrl u_ctrl (.issueValid(issueValid), .instr(instr), .strb(strb));

  icas_dpath #(.DATA_W(DATA_W), .PRED_N(8)) u_dpath (
    .strb(strb), .opA(opA), .opB(opB), .predIn(predIn),
    .carryIn(carryIn), .zeroIn(zeroIn),
    .relLt(relLt), .relEq(relEq), .relGt(relGt),
    .resVal(resVal), .zeroNew(zeroNew), .signNew(signNew)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
      destIdx  <= '0;
      destWe   <= 1'b0;
      flagWe   <= 1'b0;
      illegal  <= 1'b0;
      zeroOut  <= 1'b0;
      signOut  <= 1'b0;
      carryOut <= 1'b0;
      ovfOut   <= 1'b0;
    end else begin
      resValid <= issueValid;
      result   <= resVal;
      destIdx  <= strb.dest;
      destWe   <= strb.destWr;
      flagWe   <= strb.flagWr;
      illegal  <= strb.bad;
      if (strb.flagWr) begin
        zeroOut  <= zeroNew;
        signOut  <= signNew;
        carryOut <= 1'b0;
        ovfOut   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/icas_chk.sv
module icas_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              relLt,
  input logic              relEq,
  input logic              relGt,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        destIdx,
  input logic              destWe,
  input logic              flagWe,
  input logic              zeroOut,
  input logic              signOut,
  input logic              carryOut,
  input logic              ovfOut,
  input logic              illegal
);
  // R1
  rel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({relLt, relEq, relGt}));
  // R5
  result_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (result == '0 || result == {DATA_W{1'b1}} || result == DATA_W'(32'h3F80_0000)));
  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> resValid);
  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    destWe |-> (destIdx != 8'hFF && resValid));
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |-> (zeroOut == (result == '0)));
  // R8
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && result == {DATA_W{1'b1}}) |-> signOut);
  // R9
  carry_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |-> (!carryOut && !ovfOut));
  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!destWe && !flagWe));
  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flagWe && $past(rstN)) |-> ($stable(zeroOut) && $stable(signOut) && $stable(carryOut) && $stable(ovfOut)));
endmodule

bind icas_unit icas_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid),
  .relLt(relLt), .relEq(relEq), .relGt(relGt),
  .resValid(resValid), .result(result), .destIdx(destIdx), .destWe(destWe),
  .flagWe(flagWe), .zeroOut(zeroOut), .signOut(signOut),
  .carryOut(carryOut), .ovfOut(ovfOut), .illegal(illegal)
);

// File: tb/icas_unit_bench.sv
module icas_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [63:0] instr = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [7:0]  predIn = '0;
  logic        carryIn = 1'b0, zeroIn = 1'b0;
  logic        resValid, destWe, flagWe, zeroOut, signOut, carryOut, ovfOut, illegal;
  logic [31:0] result;
  logic [7:0]  destIdx;

  int applied = 0;
  int fails = 0;
  logic eZ = 0, eS = 0, eC = 0, eO = 0;

  always #2.5 clk = ~clk;

  icas_unit u_icas_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instr(instr),
    .opA(opA), .opB(opB), .predIn(predIn), .carryIn(carryIn), .zeroIn(zeroIn),
    .resValid(resValid), .result(result), .destIdx(destIdx), .destWe(destWe),
    .flagWe(flagWe), .zeroOut(zeroOut), .signOut(signOut), .carryOut(carryOut),
    .ovfOut(ovfOut), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] dst, input logic [2:0] ps, input logic pinv,
                                     input logic ext, input logic fres, input logic [1:0] bop,
                                     input logic ccw, input logic sgn, input logic [2:0] cop);
    logic [63:0] w = '0;
    w[7:0] = dst; w[41:39] = ps; w[42] = pinv; w[43] = ext; w[44] = fres;
    w[46:45] = bop; w[47] = ccw; w[48] = sgn; w[51:49] = cop;
    return w;
  endfunction

  // Model of the compare: widen by one tie-break bit built from the incoming flags.
  function automatic logic modelCmp(input logic [63:0] w, input logic [31:0] a, input logic [31:0] b,
                                    input logic c, input logic z);
    logic [32:0] xa, xb;
    logic lo, eq, gt;
    logic la, lb;
    if (!w[43]) begin la = 1'b0; lb = 1'b0; end
    else if (!c) begin la = 1'b0; lb = 1'b1; end
    else if (z)  begin la = 1'b1; lb = 1'b1; end
    else         begin la = 1'b1; lb = 1'b0; end
    xa = {a, la}; xb = {b, lb};
    if (w[48]) lo = $signed(xa) < $signed(xb);
    else       lo = xa < xb;
    eq = (xa == xb);
    gt = !lo && !eq;
    case (w[51:49])
      3'd0: return 1'b0;
      3'd1: return lo;
      3'd2: return eq;
      3'd3: return lo || eq;
      3'd4: return gt;
      3'd5: return !eq;
      3'd6: return gt || eq;
      default: return 1'b1;
    endcase
  endfunction

  task automatic apply(input string tag, input logic [63:0] w, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] p, input logic c, input logic z);
    logic pr, cmp, hit, bad, fw, dw;
    logic [31:0] er;
    @(negedge clk);
    issueValid = 1'b1; instr = w; opA = a; opB = b; predIn = p; carryIn = c; zeroIn = z;
    cmp = modelCmp(w, a, b, c, z);
    pr = (w[41:39] == 3'd7) ? 1'b1 : p[w[41:39]];
    if (w[42]) pr = !pr;
    case (w[46:45])
      2'd0: hit = cmp && pr;
      2'd1: hit = cmp || pr;
      2'd2: hit = cmp ^ pr;
      default: hit = 1'b0;
    endcase
    bad = (w[46:45] == 2'd3) || (w[47] && w[43]);
    er = !hit ? 32'h0 : (w[44] ? 32'h3F80_0000 : 32'hFFFF_FFFF);
    fw = w[47] && !bad;
    dw = !bad && (w[7:0] != 8'hFF);
    if (fw) begin eZ = (er == 0); eS = w[44] ? 1'b0 : (er != 0); eC = 0; eO = 0; end
    @(posedge clk);
    #1;
    issueValid = 1'b0;
    check({tag, " R6 resValid"}, {31'b0, resValid}, 32'd1);
    if (!bad) check({tag, " R5 result"}, result, er);
    check({tag, " R6 destIdx"}, {24'b0, destIdx}, {24'b0, w[7:0]});
    check({tag, " R6 destWe"}, {31'b0, destWe}, {31'b0, dw});
    check({tag, " R10 R4 illegal"}, {31'b0, illegal}, {31'b0, bad});
    check({tag, " R7 flagWe/zero"}, {30'b0, flagWe, zeroOut}, {30'b0, fw, eZ});
    check({tag, " R8 sign"}, {31'b0, signOut}, {31'b0, eS});
    check({tag, " R9 R11 carry/ovf"}, {30'b0, carryOut, ovfOut}, {30'b0, eC, eO});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 reset", {22'b0, resValid, destWe, flagWe, zeroOut, signOut, carryOut, ovfOut, illegal, 2'b0},
          32'd0);
    check("R11 reset result", result, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R1 signed vs unsigned at extremes: 0x80000000 < 1 only when signed
    apply("R1 signed lt", mk(8'd3, 3'd7, 0, 0, 0, 2'd0, 1, 1, 3'd1), 32'h8000_0000, 32'h1, 8'h00, 0, 0);
    apply("R1 unsigned lt", mk(8'd3, 3'd7, 0, 0, 0, 2'd0, 1, 0, 3'd1), 32'h8000_0000, 32'h1, 8'h00, 0, 0);
    apply("R1 ge max", mk(8'd4, 3'd7, 0, 0, 1, 2'd0, 1, 1, 3'd6), 32'h7FFF_FFFF, 32'h8000_0000, 8'h00, 0, 0);
    // R2 extended tie rules with equal upper words
    apply("R2 ext eq z", mk(8'd5, 3'd7, 0, 1, 0, 2'd0, 0, 0, 3'd2), 32'h55, 32'h55, 8'h00, 1, 1);
    apply("R2 ext eq nz", mk(8'd5, 3'd7, 0, 1, 0, 2'd0, 0, 0, 3'd2), 32'h55, 32'h55, 8'h00, 1, 0);
    apply("R2 ext borrow", mk(8'd5, 3'd7, 0, 1, 0, 2'd0, 0, 0, 3'd1), 32'h55, 32'h55, 8'h00, 0, 1);
    apply("R2 ext gt", mk(8'd5, 3'd7, 0, 1, 0, 2'd0, 0, 1, 3'd4), 32'h55, 32'h55, 8'h00, 1, 0);
    // R3 predicate 7 is true despite predIn[7]=0; inverted predicate
    apply("R3 pt", mk(8'd6, 3'd7, 0, 0, 0, 2'd0, 1, 0, 3'd7), 32'h0, 32'h0, 8'h00, 0, 0);
    apply("R3 inv", mk(8'd6, 3'd2, 1, 0, 0, 2'd0, 1, 0, 3'd7), 32'h0, 32'h0, 8'h04, 0, 0);
    // R4 reserved boolean code
    apply("R4 rsv", mk(8'd7, 3'd7, 0, 0, 0, 2'd3, 1, 0, 3'd7), 32'h0, 32'h0, 8'h00, 0, 0);
    // R6 zero register
    apply("R6 zreg", mk(8'hFF, 3'd7, 0, 0, 0, 2'd0, 0, 0, 3'd7), 32'h0, 32'h0, 8'h00, 0, 0);
    // R10 flag write with extended mode
    apply("R10 ccx", mk(8'd9, 3'd7, 0, 1, 0, 2'd1, 1, 0, 3'd0), 32'h1, 32'h2, 8'h00, 1, 0);
    // random stream
    for (int i = 0; i < 400; i++) begin
      logic [63:0] w;
      logic [31:0] a, b;
      w = {$urandom, $urandom};
      a = $urandom; b = (i % 3 == 0) ? a : $urandom;
      if (i % 5 == 0) b = a ^ 32'h8000_0000;
      apply("rand", w, a, b, 8'($urandom), 1'($urandom), 1'($urandom));
      if (i % 7 == 0) begin
        @(negedge clk);
        @(posedge clk); #1;
        check("R11 idle hold", {28'b0, zeroOut, signOut, carryOut, ovfOut}, {28'b0, eZ, eS, eC, eO});
        check("R6 idle", {30'b0, resValid, destWe}, 32'd0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule